// File: doc/BRIEF.md
# Multi-Accumulator Multiply-Accumulate Unit

This block is the integer multiply and multiply-accumulate engine of a 32-bit RISC core. It holds four accumulator pairs. Each pair has a 32-bit high word and a 32-bit low word. The core presents one decoded instruction word per cycle under a valid strobe, together with two 32-bit source operands. The unit then does one of the following to the accumulator chosen by a 2-bit field of the instruction:

- a signed or unsigned multiply;
- a multiply-add or a multiply-subtract;
- a move of either half to or from a general register.

Move-from results appear on a registered result port.

Accumulator zero has an 8-bit extension register beside it. This register counts carries out of unsigned multiply-adds into that accumulator, and a signed multiply into accumulator zero clears it. The unit raises a reserved-instruction flag for any strobed encoding it does not recognise, and such an instruction leaves all state untouched. Every operation commits on the clock edge that samples the strobe.

Top module: `mac_acc_unit`

## Requirements
- R1: On synchronous reset, all four accumulator pairs, the extension register, the result port and the reserved flag read zero.
- R2: Major opcode 000000 with function 011000 writes the product of the sign-extended sources (srcA times srcB) into the accumulator selected by instruction bits 12:11, with the high 32 bits going to HI and the low 32 bits to LO.
- R3: Major opcode 000000 with function 011001 writes the product of the zero-extended sources into the selected accumulator in the same way.
- R4: Major opcode 011100 with function 000000 adds the signed 64-bit product to {HI,LO} of the selected accumulator. Function 000001 does the same with the unsigned product. Both wrap modulo 2^64.
- R5: Major opcode 011100 with function 000100 subtracts the signed product from {HI,LO}, and function 000101 subtracts the unsigned product. Both wrap modulo 2^64.
- R6: Major opcode 000000 with function 010001 copies srcA into HI of the selected accumulator, and function 010011 copies srcA into LO.
- R7: Major opcode 000000 with function 010000 (HI) or 010010 (LO) places that half of the selected accumulator on the result port one cycle after the strobe. No other instruction changes the result port.
- R8: A signed multiply into accumulator zero clears the extension register. A signed multiply into any other accumulator leaves it unchanged.
- R9: An unsigned multiply-add into accumulator zero increments the extension register by one (wrapping at 8 bits) when the new 64-bit value is below the old one. Without such a carry, or for any other accumulator, the extension register is unchanged.
- R10: A strobed instruction that matches none of the forms above is reserved. This includes a listed form with any of bits 15:13 or 10:6 non-zero. A reserved instruction raises the reserved flag in the following cycle only, and leaves the accumulators, the extension register and the result port unchanged.
- R11: With the valid strobe low, no state changes and the reserved flag stays low.
- R12: An operation on one accumulator leaves the other three unchanged.
- R13: A move-from issued in the cycle right after an update of the same accumulator returns the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Instruction strobe, one instruction per cycle |
| instWord | input | 32 | Decoded instruction word |
| srcA | input | 32 | First source register value |
| srcB | input | 32 | Second source register value |
| result | output | 32 | Last value read by a move-from |
| resvInst | output | 1 | Reserved-instruction flag, one cycle after the strobe |
| accExt | output | 8 | Carry-extension register of accumulator zero |

## Verification
An unsigned multiply-add into accumulator zero writes the accumulator and steps the extension register on the same edge. The bench provokes this by loading all-ones into both halves and adding a product of one. It then judges both effects: the wrapped accumulator contents are read back by move-from, and the extension count is read at its port. A second overlap occurs when an accumulate and a move-from of the same accumulator land on consecutive edges. The bench issues them back to back and checks that the read returns the freshly written value rather than the stale one.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MUL,
    OP_MADD,
    OP_MSUB,
    OP_TOHI,
    OP_TOLO,
    OP_FROMHI,
    OP_FROMLO
  } macOp_e;

  localparam int SEL_W = 2;

  typedef struct packed {
    logic             commit;
    macOp_e           op;
    logic             isSigned;
    logic [SEL_W-1:0] acc;
  } macCtrl_t;

  localparam logic [5:0] MAJ_SPECIAL = 6'b000000;
  localparam logic [5:0] MAJ_ACCUM   = 6'b011100;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output macCtrl_t    ctrl,
  output logic        resvInst
);

  logic [5:0] majorOp;
  logic [5:0] funcCode;
  logic       padZero;
  logic       known;
  macOp_e     opSel;
  logic       signSel;
  logic       unusedFields;

  assign majorOp      = instWord[31:26];
  assign funcCode     = instWord[5:0];
  assign padZero      = (instWord[15:13] == 3'b000) && (instWord[10:6] == 5'b00000);
  assign unusedFields = ^instWord[25:16];

  always_comb begin
    opSel   = OP_NONE;
    signSel = 1'b0;
    known   = 1'b1;
    if (majorOp == MAJ_ACCUM) begin
      unique case (funcCode)
        6'b000000: begin opSel = OP_MADD; signSel = 1'b1; end
        6'b000001: begin opSel = OP_MADD; signSel = 1'b0; end
        6'b000100: begin opSel = OP_MSUB; signSel = 1'b1; end
        6'b000101: begin opSel = OP_MSUB; signSel = 1'b0; end
        default:   known = 1'b0;
      endcase
    end else if (majorOp == MAJ_SPECIAL) begin
      unique case (funcCode)
        6'b011000: begin opSel = OP_MUL; signSel = 1'b1; end
        6'b011001: begin opSel = OP_MUL; signSel = 1'b0; end
        6'b010000: opSel = OP_FROMHI;
        6'b010010: opSel = OP_FROMLO;
        6'b010001: opSel = OP_TOHI;
        6'b010011: opSel = OP_TOLO;
        default:   known = 1'b0;
      endcase
    end else begin
      known = 1'b0;
    end
  end

  always_comb begin
    ctrl.commit   = instValid && known && padZero;
    ctrl.op       = (known && padZero) ? opSel : OP_NONE;
    ctrl.isSigned = signSel;
    ctrl.acc      = instWord[11 +: SEL_W];
  end

  always_ff @(posedge clk) begin
    if (rst) resvInst <= 1'b0;
    else     resvInst <= instValid && !(known && padZero);
  end

  AST_RESV_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    resvInst |-> $past(instValid)); // R10

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !resvInst); // R11

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_COUNT = 4,
  parameter int EXT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  macCtrl_t          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic [EXT_W-1:0]  accExt
);

  localparam int WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] accHi [ACC_COUNT];
  logic [DATA_W-1:0] accLo [ACC_COUNT];

  logic [WIDE_W-1:0] opA, opB, product, oldVal, sumVal, diffVal;
  logic              carryOut;
  logic [ACC_COUNT-1:0] hitAcc;

  genvar g;
  generate
    for (g = 0; g < ACC_COUNT; g++) begin : gHit
      assign hitAcc[g] = ctrl.commit && (ctrl.acc == g[SEL_W-1:0]);
    end
  endgenerate

  always_comb begin
    opA      = ctrl.isSigned ? {{DATA_W{srcA[DATA_W-1]}}, srcA} : {{DATA_W{1'b0}}, srcA};
    opB      = ctrl.isSigned ? {{DATA_W{srcB[DATA_W-1]}}, srcB} : {{DATA_W{1'b0}}, srcB};
    product  = opA * opB;
    oldVal   = {accHi[ctrl.acc], accLo[ctrl.acc]};
    sumVal   = oldVal + product;
    diffVal  = oldVal - product;
    carryOut = sumVal < oldVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ACC_COUNT; k++) begin
        accHi[k] <= '0;
        accLo[k] <= '0;
      end
      result <= '0;
    end else begin
      for (int k = 0; k < ACC_COUNT; k++) begin
        if (hitAcc[k]) begin
          case (ctrl.op)
            OP_MUL:  begin accHi[k] <= product[WIDE_W-1:DATA_W]; accLo[k] <= product[DATA_W-1:0]; end
            OP_MADD: begin accHi[k] <= sumVal[WIDE_W-1:DATA_W];  accLo[k] <= sumVal[DATA_W-1:0];  end
            OP_MSUB: begin accHi[k] <= diffVal[WIDE_W-1:DATA_W]; accLo[k] <= diffVal[DATA_W-1:0]; end
            OP_TOHI: accHi[k] <= srcA;
            OP_TOLO: accLo[k] <= srcA;
            default: ;
          endcase
        end
      end
      if (ctrl.commit && ctrl.op == OP_FROMHI) result <= accHi[ctrl.acc];
      if (ctrl.commit && ctrl.op == OP_FROMLO) result <= accLo[ctrl.acc];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accExt <= '0;
    end else if (hitAcc[0]) begin
      if (ctrl.op == OP_MUL && ctrl.isSigned)
        accExt <= '0;
      else if (ctrl.op == OP_MADD && !ctrl.isSigned && carryOut)
        accExt <= accExt + 1'b1;
    end
  end

  AST_EXT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (hitAcc[0] && ctrl.op == OP_MUL && ctrl.isSigned) |=> (accExt == '0)); // R8

  AST_EXT_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(accExt) |-> (accExt == '0 || accExt == $past(accExt) + 1'b1)); // R9

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.commit && (ctrl.op == OP_FROMHI || ctrl.op == OP_FROMLO)) |=> $stable(result)); // R7

  generate
    for (g = 0; g < ACC_COUNT; g++) begin : gChk
      AST_TOHI_LANDS: assert property (@(posedge clk) disable iff (rst)
        (hitAcc[g] && ctrl.op == OP_TOHI) |=> (accHi[g] == $past(srcA))); // R6
      AST_OTHERS_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        !hitAcc[g] |=> ($stable(accHi[g]) && $stable(accLo[g]))); // R12
    end
  endgenerate

endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_COUNT = 4,
  parameter int EXT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result,
  output logic              resvInst,
  output logic [EXT_W-1:0]  accExt
);

  macCtrl_t ctrl;

  mac_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .instWord  (instWord),
    .ctrl      (ctrl),
    .resvInst  (resvInst)
  );

  mac_datapath #(
    .DATA_W    (DATA_W),
    .ACC_COUNT (ACC_COUNT),
    .EXT_W     (EXT_W)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result),
    .accExt (accExt)
  );

  AST_RESV_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    resvInst |-> ($stable(result) && $stable(accExt))); // R10

endmodule

// File: tb/sim_mac_acc_unit.sv
module sim_mac_acc_unit;

  localparam int K_MUL = 0, K_MULU = 1, K_MADD = 2, K_MADDU = 3;
  localparam int K_MSUB = 4, K_MSUBU = 5, K_TOHI = 6, K_TOLO = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] result;
  logic        resvInst;
  logic [7:0]  accExt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mHi [4];
  logic [31:0] mLo [4];
  logic [7:0]  mExt;

  always #2 clk = ~clk;

  mac_acc_unit u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .result(result), .resvInst(resvInst), .accExt(accExt)
  );

  function automatic logic [31:0] enc(input logic [5:0] maj, input logic [5:0] fn, input int acc);
    logic [1:0] a2;
    a2 = acc[1:0];
    return {maj, 10'd0, 3'b000, a2, 5'd0, fn};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, after the commit.
  task automatic issue(input logic [31:0] iw, input logic [31:0] a, input logic [31:0] b);
    instWord  = iw;
    srcA      = a;
    srcB      = b;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic readAcc(input int acc, output logic [31:0] hi, output logic [31:0] lo);
    issue(enc(6'b000000, 6'b010000, acc), '0, '0);
    hi = result;
    issue(enc(6'b000000, 6'b010010, acc), '0, '0);
    lo = result;
  endtask

  task automatic chkAcc(input int acc, input string tag);
    logic [31:0] hi, lo;
    readAcc(acc, hi, lo);
    chk(tag, {hi, lo}, {mHi[acc], mLo[acc]});
  endtask

  task automatic chkAll(input string tag);
    for (int k = 0; k < 4; k++) chkAcc(k, tag);
  endtask

  task automatic run(input int kind, input int acc, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub, p, oldV, newV;
    logic [5:0]  maj, fn;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'd0, a};
    ub = {32'd0, b};
    oldV = {mHi[acc], mLo[acc]};
    newV = oldV;
    p = (kind == K_MUL || kind == K_MADD || kind == K_MSUB) ? sa * sb : ua * ub;
    case (kind)
      K_MUL:   begin maj = 6'b000000; fn = 6'b011000; newV = p; end
      K_MULU:  begin maj = 6'b000000; fn = 6'b011001; newV = p; end
      K_MADD:  begin maj = 6'b011100; fn = 6'b000000; newV = oldV + p; end
      K_MADDU: begin maj = 6'b011100; fn = 6'b000001; newV = oldV + p; end
      K_MSUB:  begin maj = 6'b011100; fn = 6'b000100; newV = oldV - p; end
      K_MSUBU: begin maj = 6'b011100; fn = 6'b000101; newV = oldV - p; end
      K_TOHI:  begin maj = 6'b000000; fn = 6'b010001; newV = {a, oldV[31:0]}; end
      default: begin maj = 6'b000000; fn = 6'b010011; newV = {oldV[63:32], a}; end
    endcase
    if (acc == 0 && kind == K_MUL) mExt = '0;
    if (acc == 0 && kind == K_MADDU && newV < oldV) mExt = mExt + 1'b1;
    mHi[acc] = newV[63:32];
    mLo[acc] = newV[31:0];
    issue(enc(maj, fn, acc), a, b);
  endtask

  task automatic testReset();
    chk("R1 result", {32'd0, result}, 64'd0);
    chk("R1 ext", {56'd0, accExt}, 64'd0);
    chk("R1 resv", {63'd0, resvInst}, 64'd0);
    chkAll("R1 accumulators");
  endtask

  task automatic testMultiply();
    run(K_MUL, 1, 32'hFFFF_FFFD, 32'd7);
    chkAcc(1, "R2 signed mult");
    run(K_MULU, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R3 unsigned mult", {mHi[2], mLo[2]}, 64'hFFFF_FFFE_0000_0001);
    chkAcc(2, "R3 unsigned mult");
    run(K_MUL, 3, 32'h8000_0000, 32'h8000_0000);
    chkAcc(3, "R2 signed mult min*min");
    chkAll("R12 isolation after mult");
  endtask

  task automatic testAccumulate();
    run(K_MADD, 1, 32'hFFFF_FFFF, 32'd5);
    chkAcc(1, "R4 signed madd");
    run(K_MADDU, 2, 32'hFFFF_FFFF, 32'd2);
    chkAcc(2, "R4 unsigned madd");
    run(K_MSUB, 3, 32'd3, 32'hFFFF_FFFE);
    chkAcc(3, "R5 signed msub");
    run(K_MSUBU, 1, 32'hF000_0000, 32'h10);
    chkAcc(1, "R5 unsigned msub");
    chkAll("R12 isolation after accumulate");
  endtask

  task automatic testMoves();
    run(K_TOHI, 2, 32'hCAFE_0001, 32'h1234_5678);
    run(K_TOLO, 2, 32'h0BAD_F00D, 32'h1111_1111);
    issue(enc(6'b000000, 6'b010000, 2), '0, '0);
    chk("R7 move-from hi", {32'd0, result}, {32'd0, 32'hCAFE_0001});
    issue(enc(6'b000000, 6'b010010, 2), '0, '0);
    chk("R7 move-from lo", {32'd0, result}, {32'd0, 32'h0BAD_F00D});
    run(K_TOLO, 3, 32'h5555_AAAA, '0);
    chk("R7 result holds", {32'd0, result}, {32'd0, 32'h0BAD_F00D});
    chkAcc(3, "R6 move-to lo");
    chkAll("R12 isolation after moves");
  endtask

  task automatic testExtension();
    run(K_TOHI, 0, 32'hFFFF_FFFF, '0);
    run(K_TOLO, 0, 32'hFFFF_FFFF, '0);
    run(K_MADDU, 0, 32'd1, 32'd1);
    chk("R9 carry bumps ext", {56'd0, accExt}, 64'd1);
    chkAcc(0, "R9 wrapped acc0");
    run(K_MADDU, 0, 32'd3, 32'd4);
    chk("R9 no carry keeps ext", {56'd0, accExt}, {56'd0, mExt});
    run(K_TOHI, 2, 32'hFFFF_FFFF, '0);
    run(K_TOLO, 2, 32'hFFFF_FFFF, '0);
    run(K_MADDU, 2, 32'd9, 32'd9);
    chk("R9 other acc no bump", {56'd0, accExt}, 64'd1);
    run(K_MUL, 1, 32'd2, 32'd3);
    chk("R8 mult acc1 keeps ext", {56'd0, accExt}, 64'd1);
    run(K_MULU, 0, 32'd2, 32'd3);
    chk("R8 unsigned mult keeps ext", {56'd0, accExt}, 64'd1);
    run(K_MUL, 0, 32'd2, 32'd3);
    chk("R8 signed mult acc0 clears", {56'd0, accExt}, 64'd0);
    for (int i = 0; i < 256; i++) begin
      run(K_TOHI, 0, 32'hFFFF_FFFF, '0);
      run(K_TOLO, 0, 32'hFFFF_FFFF, '0);
      run(K_MADDU, 0, 32'd1, 32'd1);
    end
    chk("R9 ext wraps at 8 bits", {56'd0, accExt}, 64'd0);
  endtask

  task automatic testBackToBack();
    run(K_MADD, 3, 32'd100, 32'd100);
    issue(enc(6'b000000, 6'b010010, 3), '0, '0);
    chk("R13 immediate read", {32'd0, result}, {32'd0, mLo[3]});
  endtask

  task automatic testReserved();
    logic [31:0] keepRes;
    logic [7:0]  keepExt;
    keepRes = result;
    keepExt = accExt;
    issue(enc(6'b000000, 6'b111111, 1), 32'hDEAD_BEEF, 32'd1);
    chk("R10 flag raised", {63'd0, resvInst}, 64'd1);
    chk("R10 result kept", {32'd0, result}, {32'd0, keepRes});
    chk("R10 ext kept", {56'd0, accExt}, {56'd0, keepExt});
    @(negedge clk);
    chk("R10 flag one cycle", {63'd0, resvInst}, 64'd0);
    issue(enc(6'b000000, 6'b010001, 1) | 32'h0000_0080, 32'hDEAD_BEEF, '0);
    chk("R10 pad bits flag", {63'd0, resvInst}, 64'd1);
    issue(enc(6'b011100, 6'b000001, 0) | 32'h0000_4000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R10 high pad flag", {63'd0, resvInst}, 64'd1);
    issue(enc(6'b010101, 6'b011000, 2), 32'd7, 32'd7);
    chk("R10 bad major flag", {63'd0, resvInst}, 64'd1);
    chk("R10 ext kept after madd-like", {56'd0, accExt}, {56'd0, keepExt});
    chkAll("R10 no state change");
  endtask

  task automatic testIdle();
    instWord  = enc(6'b000000, 6'b010001, 0);
    srcA      = 32'h1357_9BDF;
    instValid = 1'b0;
    @(negedge clk);
    chk("R11 no flag when idle", {63'd0, resvInst}, 64'd0);
    instWord = enc(6'b000000, 6'b111111, 0);
    @(negedge clk);
    chk("R11 bad word idle no flag", {63'd0, resvInst}, 64'd0);
    chkAcc(0, "R11 idle no write");
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin mHi[k] = '0; mLo[k] = '0; end
    mExt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testMultiply();
    testAccumulate();
    testMoves();
    testExtension();
    testBackToBack();
    testReserved();
    testIdle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule